// File: doc/BRIEF.md
# Reference Qualification Monitor

This block decides whether a timing reference can be trusted. Three upstream detectors each raise a flag while their threshold is exceeded: a per-cycle period check, a coarse frequency check and a fine frequency check. Every flag first passes through a debounce filter. The filtered flags then drive three outputs: a combined failure status, a holdover request for the downstream loop, and a qualified/disqualified verdict.

The verdict comes from a leaky timer that runs on a slow tick supplied from outside. While a period or coarse failure is present, the timer climbs four steps per tick. Otherwise it drains one step per tick. The reference is disqualified when the timer reaches its ceiling and qualified again only once the timer has drained to zero. Short outages are never forgotten at once, so a series of them can add up to a disqualification. The fine frequency flag is reported in the failure status only: it neither requests holdover nor feeds the timer.

Top module: `refq_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the timer and the filters; after that edge `fail_o`, `holdover_o` and `disq_o` are all 0, which means the reference is qualified and in normal mode.
- R2: A monitor input takes effect only after it has held a new level for FILT_LEN consecutive clock edges. The filtered flag changes at the FILT_LEN-th such edge. A change that lasts fewer edges has no effect on any output.
- R3: `fail_o` is high exactly when at least one of the three filtered flags (period, coarse, fine) is high.
- R4: `holdover_o` is high exactly when the filtered period flag or the filtered coarse flag is high. It returns to 0 as soon as both clear.
- R5: At each clock edge where `tick_i` is 1, the timer rises by UP_STEP, saturating at LIMIT = TICKS_DISQ*UP_STEP, while holdover is requested; otherwise it falls by DN_STEP, stopping at 0. It does not change at edges without a tick.
- R6: `disq_o` rises at the tick edge where the timer reaches LIMIT. From an empty timer under continuous failure, this is the TICKS_DISQ-th tick.
- R7: Once set, `disq_o` stays high until the timer drains to 0. From a full timer that takes LIMIT/DN_STEP failure-free ticks.
- R8: Failures that are each too short to disqualify add together in the timer and eventually raise `disq_o` when failure time outweighs clear time by the step ratio.
- R9: The fine frequency flag raises `fail_o` only. It never raises `holdover_o` and never moves the timer or `disq_o`, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle time-base strobe for the timer |
| cyc_fail_i | input | 1 | Per-cycle period monitor failure flag |
| crs_fail_i | input | 1 | Coarse frequency monitor failure flag |
| fine_fail_i | input | 1 | Fine frequency monitor failure flag |
| fail_o | output | 1 | Combined filtered failure status |
| holdover_o | output | 1 | Holdover request (0 = normal mode) |
| disq_o | output | 1 | Reference disqualified |

## Verification
The bench builds the block with FILT_LEN=4, TICKS_DISQ=5 and its own tick every 8 clocks. With these values a full disqualification takes 40 cycles and a full requalification 160 cycles, so sustained outages, intermittent outages, complete drain-back and saturation all fit in a few hundred cycles. The short filter lets glitches of 3 cycles be shown to be ignored while 4-cycle levels are accepted. A reference model compares every output on every cycle.

// File: rtl/refq_pkg.sv
package refq_pkg;

   localparam int unsigned NUM_MON = 3;

   typedef enum int unsigned {
      MON_CYCLE  = 0,
      MON_COARSE = 1,
      MON_FINE   = 2
   } mon_idx_e;

   function automatic int unsigned width_for(int unsigned max_value);
      return (max_value < 2) ? 1 : $clog2(max_value + 1);
   endfunction

endpackage

// File: rtl/refq_debounce.sv
module refq_debounce #(
   parameter int unsigned FILT_LEN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_i,
   output logic flag_o
);
   import refq_pkg::*;

   logic flag_q;

   if (FILT_LEN < 1) begin : g_bad_len
      $error("refq_debounce: FILT_LEN must be at least 1");
   end

   if (FILT_LEN == 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (rst) flag_q <= 1'b0;
         else     flag_q <= raw_i;
      end
   end else begin : g_counted
      localparam int unsigned RW = width_for(FILT_LEN - 1);
      localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);
      logic [RW-1:0] run_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            flag_q <= 1'b0;
            run_q  <= '0;
         end else if (raw_i == flag_q) begin
            run_q  <= '0;
         end else if (run_q == RUN_LAST) begin
            flag_q <= raw_i;
            run_q  <= '0;
         end else begin
            run_q  <= run_q + 1'b1;
         end
      end

      // R2: the accepted level only moves to a level that was present at the edge
      p_accept_seen_r2: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$stable(flag_q)) |-> ($past(raw_i) == flag_q));
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/refq_leak_timer.sv
module refq_leak_timer #(
   parameter int unsigned TICKS_DISQ = 250,
   parameter int unsigned UP_STEP    = 4,
   parameter int unsigned DN_STEP    = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic bad_i,
   output logic disq_o
);
   import refq_pkg::*;

   localparam int unsigned LIMIT = TICKS_DISQ * UP_STEP;
   localparam int unsigned CW    = width_for(LIMIT);
   localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);
   localparam logic [CW-1:0] CNT_DN  = CW'(DN_STEP);
   localparam logic [CW:0]   SUM_MAX = (CW+1)'(LIMIT);
   localparam logic [CW:0]   SUM_UP  = (CW+1)'(UP_STEP);

   if (TICKS_DISQ < 1 || UP_STEP < 1 || DN_STEP < 1) begin : g_bad_cfg
      $error("refq_leak_timer: TICKS_DISQ, UP_STEP and DN_STEP must be at least 1");
   end
   if (DN_STEP > LIMIT) begin : g_bad_dn
      $error("refq_leak_timer: DN_STEP must not exceed the ceiling");
   end

   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW:0]   up_sum;
   logic          disq_q, disq_d;

   assign up_sum = {1'b0, cnt_q} + SUM_UP;

   always_comb begin
      cnt_d = cnt_q;
      if (tick_i) begin
         if (bad_i) begin
            cnt_d = (up_sum >= SUM_MAX) ? CNT_MAX : up_sum[CW-1:0];
         end else begin
            cnt_d = (cnt_q >= CNT_DN) ? (cnt_q - CNT_DN) : '0;
         end
      end
   end

   always_comb begin
      disq_d = disq_q;
      if (cnt_d == CNT_MAX)  disq_d = 1'b1;
      else if (cnt_d == '0)  disq_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         disq_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         disq_q <= disq_d;
      end
   end

   assign disq_o = disq_q;

   // R5: the count never passes the ceiling
   always_comb begin
      if (!rst) p_ceiling_r5: assert (cnt_q <= CNT_MAX);
   end

   // R5: the count moves only on tick edges
   p_tick_only_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(tick_i)) |-> $stable(cnt_q));

   // R6: disqualification appears only with a full count
   p_disq_at_full_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(disq_q)) |-> (cnt_q == CNT_MAX));

   // R7: requalification appears only with an empty count
   p_requal_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(disq_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/refq_monitor.sv
module refq_monitor #(
   parameter int unsigned FILT_LEN   = 16,
   parameter int unsigned TICKS_DISQ = 250,
   parameter int unsigned UP_STEP    = 4,
   parameter int unsigned DN_STEP    = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic cyc_fail_i,
   input  logic crs_fail_i,
   input  logic fine_fail_i,
   output logic fail_o,
   output logic holdover_o,
   output logic disq_o
);
   import refq_pkg::*;

   logic [NUM_MON-1:0] raw_flags;
   logic [NUM_MON-1:0] filt_flags;
   logic               hold_req;

   assign raw_flags[MON_CYCLE]  = cyc_fail_i;
   assign raw_flags[MON_COARSE] = crs_fail_i;
   assign raw_flags[MON_FINE]   = fine_fail_i;

   for (genvar m = 0; m < NUM_MON; m++) begin : g_filt
      refq_debounce #(
         .FILT_LEN (FILT_LEN)
      ) u_filt (
         .clk    (clk),
         .rst    (rst),
         .raw_i  (raw_flags[m]),
         .flag_o (filt_flags[m])
      );
   end

   assign hold_req = filt_flags[MON_CYCLE] | filt_flags[MON_COARSE];

   refq_leak_timer #(
      .TICKS_DISQ (TICKS_DISQ),
      .UP_STEP    (UP_STEP),
      .DN_STEP    (DN_STEP)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick_i),
      .bad_i  (hold_req),
      .disq_o (disq_o)
   );

   assign fail_o     = |filt_flags;
   assign holdover_o = hold_req;

   // R4: a holdover request is always accompanied by the failure status
   p_hold_in_fail_r4: assert property (@(posedge clk) disable iff (rst)
      holdover_o |-> fail_o);

endmodule

// File: tb/sim_refq_monitor.sv
`timescale 1ns/1ps
module sim_refq_monitor;
   localparam int FL   = 4;
   localparam int TD   = 5;
   localparam int UP   = 4;
   localparam int DN   = 1;
   localparam int TPER = 8;
   localparam int LIM  = TD * UP;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, tick = 1'b0, scm = 1'b0, cfm = 1'b0, pfm = 1'b0;
   logic fail, hold, disq;

   refq_monitor #(.FILT_LEN(FL), .TICKS_DISQ(TD), .UP_STEP(UP), .DN_STEP(DN)) u0 (
      .clk(clk), .rst(rst), .tick_i(tick), .cyc_fail_i(scm), .crs_fail_i(cfm),
      .fine_fail_i(pfm), .fail_o(fail), .holdover_o(hold), .disq_o(disq));

   typedef struct { logic f; logic h; logic d; string tag; } exp_t;
   exp_t  sb_q[$];
   string phase = "R1 reset";
   int    nchk = 0, nbad = 0;
   bit    done = 0;

   // time base strobe
   int tc = 0;
   always @(negedge clk) begin
      if (tc == TPER-1) begin tick = 1'b1; tc = 0; end
      else begin tick = 1'b0; tc++; end
   end

   // reference model built from the requirements
   int   m_run[3];
   logic m_acc[3];
   int   m_cnt = 0;
   logic m_dq  = 1'b0;
   always @(posedge clk) begin
      logic raw[3];
      logic bad_now;
      exp_t e;
      raw[0] = scm; raw[1] = cfm; raw[2] = pfm;
      if (rst) begin
         for (int i = 0; i < 3; i++) begin m_acc[i] = 1'b0; m_run[i] = 0; end
         m_cnt = 0; m_dq = 1'b0;
      end else begin
         bad_now = m_acc[0] | m_acc[1];
         if (tick) begin
            if (bad_now) m_cnt = (m_cnt + UP > LIM) ? LIM : m_cnt + UP;
            else         m_cnt = (m_cnt > DN) ? m_cnt - DN : 0;
            if (m_cnt == LIM)    m_dq = 1'b1;
            else if (m_cnt == 0) m_dq = 1'b0;
         end
         for (int i = 0; i < 3; i++) begin
            if (raw[i] == m_acc[i]) m_run[i] = 0;
            else if (m_run[i] == FL-1) begin m_acc[i] = raw[i]; m_run[i] = 0; end
            else m_run[i]++;
         end
      end
      e.f = m_acc[0] | m_acc[1] | m_acc[2];
      e.h = m_acc[0] | m_acc[1];
      e.d = m_dq;
      e.tag = phase;
      sb_q.push_back(e);
   end

   // monitor: compare each produced result against the queued expectation
   always @(negedge clk) begin
      exp_t e;
      if (sb_q.size() > 0 && !done) begin
         e = sb_q.pop_front();
         nchk++;
         if (fail !== e.f) begin nbad++; $display("FAIL %s (R3 fail_o): actual %b expected %b at %0t", e.tag, fail, e.f, $time); end
         if (hold !== e.h) begin nbad++; $display("FAIL %s (R4 holdover_o): actual %b expected %b at %0t", e.tag, hold, e.h, $time); end
         if (disq !== e.d) begin nbad++; $display("FAIL %s (R6/R7 disq_o): actual %b expected %b at %0t", e.tag, disq, e.d, $time); end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", nchk - nbad, nchk);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      nchk++; nbad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      phase = "R1 reset"; rst = 1'b1;
      cyc(5);
      rst = 1'b0;
      phase = "R1 idle after reset"; cyc(6);

      phase = "R2 short glitch ignored";
      scm = 1'b1; cyc(3); scm = 1'b0; cyc(8);
      cfm = 1'b1; cyc(1); cfm = 1'b0; cyc(8);

      phase = "R9 R3 fine flag only";
      pfm = 1'b1; cyc(100); pfm = 1'b0; cyc(10);

      phase = "R4 R5 R6 sustained coarse";
      cfm = 1'b1; cyc(30);
      phase = "R2 short dropout ignored";
      cfm = 1'b0; cyc(2); cfm = 1'b1;
      phase = "R5 R6 saturate";
      cyc(50);
      phase = "R4 R7 drain to requalify";
      cfm = 1'b0; cyc(200);

      phase = "R8 intermittent period failures";
      for (int k = 0; k < 8; k++) begin
         scm = 1'b1; cyc(20);
         scm = 1'b0; cyc(12);
      end
      phase = "R7 requalify after intermittent";
      cyc(220);

      phase = "R3 all flags together";
      scm = 1'b1; cfm = 1'b1; pfm = 1'b1; cyc(20);
      phase = "R1 reset mid run";
      rst = 1'b1; cyc(3); rst = 1'b0;
      phase = "R2 refilter after reset";
      cyc(10);
      scm = 1'b0; cfm = 1'b0; pfm = 1'b0; cyc(20);
      finish_run();
   end
endmodule